// File: doc/BRIEF.md
# Frame and Continuation Thread Scheduler

This block sequences fine-grained threads that are grouped into activation frames. It schedules on two levels. Inside the running frame, a small last-in-first-out stack holds the start addresses of pending threads. A fork pushes an address onto that stack. A stop takes the most recent address off it and presents it as the next thread to run. The frame's exit thread always sits beneath every stacked entry. A stop that finds no stacked address therefore presents the exit address. That thread's job is to leave the frame and ask for the next one.

Across frames, a first-in-first-out queue holds the frames that are ready to run. A post to a frame that is not running pushes the supplied thread address onto that frame's own stack. Only the first such post queues the frame; a per-frame flag suppresses duplicate entries. A swap is honoured only once the running frame's stack is empty. It then removes the oldest queued frame and issues that frame's entry address. When nothing is queued, a swap leaves the scheduler idle. The next post then wakes the posted frame directly.

The block takes one command per clock. Every result it produces is a registered one-cycle pulse carrying an address and a frame number.

Top module: `frame_thread_sched`

## Requirements
- R1: After reset, `next_valid` and `stack_ovf` are 0 and no frame is running.
- R2: ALLOC (`cmd_op`=5) records `cmd_pc` as the entry address and `cmd_exit_pc` as the exit address of frame `cmd_frame`, without a pulse. It is ignored when that frame is running or queued.
- R3: FORK (`cmd_op`=1) pushes `cmd_pc` onto the running frame's stack. STOP (`cmd_op`=2) pops addresses in last-in-first-out order. Each STOP gives a `next_valid` pulse in the cycle after the command edge, with `next_frame` set to the running frame.
- R4: A STOP on an empty stack presents the running frame's exit address, and the exit address remains for any further STOP.
- R5: POST (`cmd_op`=3) to the running frame pushes onto its stack, gives no pulse and does not queue the frame.
- R6: POST to a frame that is not running, while another frame runs, pushes onto that frame's stack. It queues the frame only if the frame is not already queued. Frames leave the queue in arrival order, each once.
- R7: SWAP (`cmd_op`=4) with the running stack empty dequeues the oldest frame. It presents that frame's entry address and makes the frame the running one. The frame's queued flag is cleared, so a later post queues it again.
- R8: SWAP while the running frame's stack holds entries is ignored: no pulse, and the same frame keeps running.
- R9: SWAP with an empty queue gives no pulse and leaves no frame running. A POST while idle makes the posted frame run, stacks the address and presents the frame's entry address.
- R10: A push onto a stack that already holds DEPTH entries is dropped and sets `stack_ovf`, which stays set until reset.
- R11: FORK and STOP while no frame is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command: 0 none, 1 fork, 2 stop, 3 post, 4 swap, 5 alloc |
| cmd_frame | input | $clog2(NF) | Target frame for post and alloc |
| cmd_pc | input | PCW | Thread address (fork, post) or entry address (alloc) |
| cmd_exit_pc | input | PCW | Exit address (alloc) |
| next_valid | output | 1 | One-cycle pulse: a thread address is issued |
| next_pc | output | PCW | Issued thread address |
| next_frame | output | $clog2(NF) | Frame the issued address belongs to |
| stack_ovf | output | 1 | Sticky flag for a dropped push |

## Verification
Every result of this block appears in the clock cycle right after the edge that accepts the command. This holds for a popped or exit address, an entry address after a swap or wake-up, a missing pulse for a refused command, and the overflow flag. No command has a longer path. The bench changes inputs on the falling edge, waits one rising edge, and samples on the next falling edge, so each check lands on that one cycle. Stack and queue contents are never read directly. They are observed by later stops and swaps, so dropped pushes, refused allocations and unduplicated queue entries all show up in the order and values of issued addresses.

// File: rtl/tsched_pkg.sv
package tsched_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_FORK  = 3'd1,
    OP_STOP  = 3'd2,
    OP_POST  = 3'd3,
    OP_SWAP  = 3'd4,
    OP_ALLOC = 3'd5
  } op_e;

  // circular pointer step over n slots
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // a stack of depth d holding c entries can accept another
  function automatic logic has_room(input int unsigned c, input int unsigned d);
    return c < d;
  endfunction

endpackage

// File: rtl/cont_stack_bank.sv
module cont_stack_bank
  import tsched_pkg::*;
#(
  parameter int NF    = 4,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int FW   = (NF > 1) ? $clog2(NF) : 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [FW-1:0]  sel,
  input  logic           push_en,
  input  logic           pop_en,
  input  logic [PCW-1:0] push_pc,
  output logic [PCW-1:0] top_pc,
  output logic           full,
  output logic           empty
);

  logic [NF-1:0][CW-1:0]  cnt_all;
  logic [NF-1:0][PCW-1:0] top_all;

  generate
    for (genvar g = 0; g < NF; g++) begin : g_frame
      logic [PCW-1:0] mem [DEPTH];
      logic [CW-1:0]  cnt;
      logic           hit;

      assign hit = (sel == FW'(g));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (hit) begin
          if (push_en && has_room(int'(cnt), DEPTH)) begin
            mem[cnt[AW-1:0]] <= push_pc;
            cnt <= cnt + CW'(1);
          end else if (pop_en && cnt != '0) begin
            cnt <= cnt - CW'(1);
          end
        end
      end

      assign cnt_all[g] = cnt;
      assign top_all[g] = (cnt == '0) ? '0 : mem[AW'(cnt - CW'(1))];
    end
  endgenerate

  assign top_pc = top_all[sel];
  assign full   = !has_room(int'(cnt_all[sel]), DEPTH);
  assign empty  = (cnt_all[sel] == '0);

  // R10 the controller filters pushes onto a full stack
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> !full);

  // R4 an empty stack yields the exit address, never a pop
  pop_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> !empty);

endmodule

// File: rtl/ready_fifo.sv
module ready_fifo
  import tsched_pkg::*;
#(
  parameter int NF  = 4,
  localparam int FW = (NF > 1) ? $clog2(NF) : 1,
  localparam int QW = $clog2(NF + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [FW-1:0] push_id,
  input  logic          pop,
  output logic [FW-1:0] head_id,
  output logic          empty,
  output logic [QW-1:0] used
);

  logic [FW-1:0] slots [NF];
  logic [FW-1:0] rd_ptr, wr_ptr;
  logic          full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      used   <= '0;
    end else begin
      if (push) begin
        slots[wr_ptr] <= push_id;
        wr_ptr <= FW'(wrap_inc(int'(wr_ptr), NF));
      end
      if (pop) begin
        rd_ptr <= FW'(wrap_inc(int'(rd_ptr), NF));
      end
      if (push && !pop)      used <= used + QW'(1);
      else if (pop && !push) used <= used - QW'(1);
    end
  end

  assign head_id = slots[rd_ptr];
  assign empty   = (used == '0);
  assign full    = (used == QW'(NF));

  // R6 duplicate suppression keeps the queue within one slot per frame
  fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7 a dequeue only happens with a queued frame present
  fifo_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/frame_thread_sched.sv
module frame_thread_sched
  import tsched_pkg::*;
#(
  parameter int NF    = 4,
  parameter int DEPTH = 8,
  parameter int PCW   = 16,
  localparam int FW   = (NF > 1) ? $clog2(NF) : 1,
  localparam int QW   = $clog2(NF + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     cmd_op,
  input  logic [FW-1:0]  cmd_frame,
  input  logic [PCW-1:0] cmd_pc,
  input  logic [PCW-1:0] cmd_exit_pc,
  output logic           next_valid,
  output logic [PCW-1:0] next_pc,
  output logic [FW-1:0]  next_frame,
  output logic           stack_ovf
);

  op_e op;
  assign op = op_e'(cmd_op);

  // frame state
  logic           active_vld;
  logic [FW-1:0]  active_id;
  logic [NF-1:0]  queued;
  logic [PCW-1:0] entry_pc [NF];
  logic [PCW-1:0] exit_pc  [NF];

  // stack bank and queue wires
  logic [FW-1:0]  bk_sel;
  logic           bk_push, bk_pop, bk_full, bk_empty;
  logic [PCW-1:0] bk_top;
  logic           q_push, q_pop, q_empty;
  logic [FW-1:0]  q_head;
  logic [QW-1:0]  q_used;

  // named events
  logic on_running;
  logic ev_fork, ev_stop, ev_post, ev_wake, ev_post_remote, ev_enq;
  logic ev_swap_req, ev_swap_ok, ev_swap_go, ev_swap_idle, ev_alloc;
  logic want_push, push_drop;

  assign on_running     = active_vld && (cmd_frame == active_id);
  assign ev_fork        = (op == OP_FORK) && active_vld;
  assign ev_stop        = (op == OP_STOP) && active_vld;
  assign ev_post        = (op == OP_POST);
  assign ev_wake        = ev_post && !active_vld;
  assign ev_post_remote = ev_post && active_vld && !on_running;
  assign ev_enq         = ev_post_remote && !queued[cmd_frame];
  assign ev_swap_req    = (op == OP_SWAP);
  assign ev_swap_ok     = ev_swap_req && (!active_vld || bk_empty);
  assign ev_swap_go     = ev_swap_ok && !q_empty;
  assign ev_swap_idle   = ev_swap_ok && q_empty;
  assign ev_alloc       = (op == OP_ALLOC) && !on_running && !queued[cmd_frame];

  assign bk_sel    = (ev_post || op == OP_ALLOC) ? cmd_frame : active_id;
  assign want_push = ev_fork || ev_post;
  assign bk_push   = want_push && !bk_full;
  assign push_drop = want_push && bk_full;
  assign bk_pop    = ev_stop && !bk_empty;
  assign q_push    = ev_enq;
  assign q_pop     = ev_swap_go;

  cont_stack_bank #(.NF(NF), .DEPTH(DEPTH), .PCW(PCW)) u_stacks (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (bk_sel),
    .push_en (bk_push),
    .pop_en  (bk_pop),
    .push_pc (cmd_pc),
    .top_pc  (bk_top),
    .full    (bk_full),
    .empty   (bk_empty)
  );

  ready_fifo #(.NF(NF)) u_ready (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (q_push),
    .push_id (cmd_frame),
    .pop     (q_pop),
    .head_id (q_head),
    .empty   (q_empty),
    .used    (q_used)
  );

  // running frame selection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_vld <= 1'b0;
      active_id  <= '0;
    end else if (ev_swap_go) begin
      active_vld <= 1'b1;
      active_id  <= q_head;
    end else if (ev_swap_idle) begin
      active_vld <= 1'b0;
    end else if (ev_wake) begin
      active_vld <= 1'b1;
      active_id  <= cmd_frame;
    end
  end

  // per-frame queued flags and thread addresses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      queued <= '0;
      for (int i = 0; i < NF; i++) begin
        entry_pc[i] <= '0;
        exit_pc[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (ev_enq && cmd_frame == FW'(i))          queued[i] <= 1'b1;
        else if (ev_swap_go && q_head == FW'(i))    queued[i] <= 1'b0;
        if (ev_alloc && cmd_frame == FW'(i)) begin
          entry_pc[i] <= cmd_pc;
          exit_pc[i]  <= cmd_exit_pc;
        end
      end
    end
  end

  // issued thread
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_valid <= 1'b0;
      next_pc    <= '0;
      next_frame <= '0;
      stack_ovf  <= 1'b0;
    end else begin
      next_valid <= ev_stop || ev_swap_go || ev_wake;
      if (ev_stop) begin
        next_pc    <= bk_empty ? exit_pc[active_id] : bk_top;
        next_frame <= active_id;
      end else if (ev_swap_go) begin
        next_pc    <= entry_pc[q_head];
        next_frame <= q_head;
      end else if (ev_wake) begin
        next_pc    <= entry_pc[cmd_frame];
        next_frame <= cmd_frame;
      end
      if (push_drop) stack_ovf <= 1'b1;
    end
  end

  // R3 a stop on a running frame issues on the next cycle for that frame
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> next_valid && next_frame == $past(active_id));

  // R8 a swap with stacked work left changes nothing
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_swap_req && active_vld && !bk_empty) |=> !next_valid && active_vld && $stable(active_id));

  // R6 one queue slot per queued flag
  queue_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(queued) == int'(q_used));

  // R7 the running frame never waits in the queue
  active_not_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_vld |-> !queued[active_id]);

  // R9 an idle scheduler has nothing queued
  idle_queue_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_vld |-> q_empty);

  // R11 without a running frame only a post produces a pulse
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_vld && !ev_post) |=> !next_valid);

  // R10 the overflow flag is sticky
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);

endmodule

// File: tb/frame_thread_sched_test.sv
`timescale 1ns/1ps
module frame_thread_sched_test;

  localparam logic [2:0] C_NOP = 3'd0, C_FORK = 3'd1, C_STOP = 3'd2,
                         C_POST = 3'd3, C_SWAP = 3'd4, C_ALLOC = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_op = C_NOP;
  logic [1:0]  cmd_frame = '0;
  logic [15:0] cmd_pc = '0;
  logic [15:0] cmd_exit_pc = '0;
  logic        next_valid;
  logic [15:0] next_pc;
  logic [1:0]  next_frame;
  logic        stack_ovf;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  frame_thread_sched #(.NF(4), .DEPTH(8), .PCW(16)) uut (
    .clk (clk), .rst_n (rst_n), .cmd_op (cmd_op), .cmd_frame (cmd_frame),
    .cmd_pc (cmd_pc), .cmd_exit_pc (cmd_exit_pc), .next_valid (next_valid),
    .next_pc (next_pc), .next_frame (next_frame), .stack_ovf (stack_ovf)
  );

  function automatic logic [15:0] ent(input int f); return 16'h1000 + 16'(f); endfunction
  function automatic logic [15:0] ext(input int f); return 16'h2000 + 16'(f); endfunction

  // drive on a falling edge, let one rising edge take it, sample on the next falling edge
  task automatic issue(input logic [2:0] op, input logic [1:0] fr,
                       input logic [15:0] pc, input logic [15:0] xpc);
    cmd_op = op; cmd_frame = fr; cmd_pc = pc; cmd_exit_pc = xpc;
    @(posedge clk);
    @(negedge clk);
    cmd_op = C_NOP;
  endtask

  task automatic want_pc(input string req, input logic [15:0] pc, input logic [1:0] fr);
    checks++;
    if (!(next_valid === 1'b1 && next_pc === pc && next_frame === fr)) begin
      errors++;
      $display("FAIL %s: valid=%0b pc=%h frame=%0d, expected valid=1 pc=%h frame=%0d",
               req, next_valid, next_pc, next_frame, pc, fr);
    end
  endtask

  task automatic want_quiet(input string req);
    checks++;
    if (next_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: valid=%0b, expected valid=0", req, next_valid);
    end
  endtask

  task automatic want_ovf(input string req, input logic v);
    checks++;
    if (stack_ovf !== v) begin
      errors++;
      $display("FAIL %s: stack_ovf=%0b, expected %0b", req, stack_ovf, v);
    end
  endtask

  task automatic stop_is(input string req, input logic [15:0] pc, input logic [1:0] fr);
    issue(C_STOP, 2'd0, 16'h0, 16'h0);
    want_pc(req, pc, fr);
  endtask

  task automatic quiet_cmd(input string req, input logic [2:0] op, input logic [1:0] fr,
                           input logic [15:0] pc);
    issue(op, fr, pc, 16'h0);
    want_quiet(req);
  endtask

  task automatic t_reset();
    want_quiet("R1 reset valid");
    want_ovf("R1 reset overflow", 1'b0);
    quiet_cmd("R11 stop while idle", C_STOP, 2'd0, 16'h0);
    quiet_cmd("R11 fork while idle", C_FORK, 2'd0, 16'h0BAD);
    quiet_cmd("R9 swap with nothing queued", C_SWAP, 2'd0, 16'h0);
  endtask

  task automatic t_alloc();
    for (int f = 0; f < 4; f++) begin
      issue(C_ALLOC, 2'(f), ent(f), ext(f));
      want_quiet("R2 alloc gives no pulse");
    end
  endtask

  task automatic t_wake();
    issue(C_POST, 2'd0, 16'h3000, 16'h0);
    want_pc("R9 post wakes idle frame", ent(0), 2'd0);
    stop_is("R9 posted thread stacked, R11 idle fork dropped", 16'h3000, 2'd0);
    stop_is("R4 exit at bottom", ext(0), 2'd0);
    stop_is("R4 exit remains", ext(0), 2'd0);
  endtask

  task automatic t_lifo();
    quiet_cmd("R3 fork quiet", C_FORK, 2'd0, 16'h3101);
    quiet_cmd("R3 fork quiet", C_FORK, 2'd0, 16'h3102);
    quiet_cmd("R3 fork quiet", C_FORK, 2'd0, 16'h3103);
    stop_is("R3 lifo first", 16'h3103, 2'd0);
    stop_is("R3 lifo second", 16'h3102, 2'd0);
    stop_is("R3 lifo third", 16'h3101, 2'd0);
    stop_is("R4 exit after forks", ext(0), 2'd0);
  endtask

  task automatic t_post_active();
    quiet_cmd("R5 post to running frame", C_POST, 2'd0, 16'h3200);
    stop_is("R5 post landed on running stack", 16'h3200, 2'd0);
    stop_is("R5 exit after post", ext(0), 2'd0);
    quiet_cmd("R5 running frame was not queued", C_SWAP, 2'd0, 16'h0);
    issue(C_POST, 2'd1, 16'h5101, 16'h0);
    want_pc("R9 wake second frame", ent(1), 2'd1);
  endtask

  task automatic t_enqueue();
    quiet_cmd("R6 remote post", C_POST, 2'd2, 16'h5201);
    quiet_cmd("R6 remote post", C_POST, 2'd2, 16'h5202);
    quiet_cmd("R6 remote post", C_POST, 2'd3, 16'h5301);
    quiet_cmd("R6 remote post", C_POST, 2'd2, 16'h5203);
    quiet_cmd("R8 swap with work left", C_SWAP, 2'd0, 16'h0);
    stop_is("R8 same frame still runs", 16'h5101, 2'd1);
    stop_is("R4 exit of frame 1", ext(1), 2'd1);
    issue(C_SWAP, 2'd0, 16'h0, 16'h0);
    want_pc("R7 swap to oldest queued", ent(2), 2'd2);
    stop_is("R6 posts stacked", 16'h5203, 2'd2);
    stop_is("R6 posts stacked", 16'h5202, 2'd2);
    stop_is("R6 posts stacked", 16'h5201, 2'd2);
    stop_is("R4 exit of frame 2", ext(2), 2'd2);
    issue(C_SWAP, 2'd0, 16'h0, 16'h0);
    want_pc("R6 queue order", ent(3), 2'd3);
    stop_is("R6 post to frame 3", 16'h5301, 2'd3);
    stop_is("R4 exit of frame 3", ext(3), 2'd3);
    quiet_cmd("R6 no duplicate queue entry", C_SWAP, 2'd0, 16'h0);
  endtask

  task automatic t_requeue();
    issue(C_POST, 2'd2, 16'h7200, 16'h0);
    want_pc("R9 wake frame 2", ent(2), 2'd2);
    quiet_cmd("R6 queue frame 3", C_POST, 2'd3, 16'h7300);
    stop_is("R3 frame 2 thread", 16'h7200, 2'd2);
    stop_is("R4 frame 2 exit", ext(2), 2'd2);
    issue(C_SWAP, 2'd0, 16'h0, 16'h0);
    want_pc("R7 swap to frame 3", ent(3), 2'd3);
    quiet_cmd("R7 post to previously dequeued frame", C_POST, 2'd2, 16'h7201);
    stop_is("R3 frame 3 thread", 16'h7300, 2'd3);
    stop_is("R4 frame 3 exit", ext(3), 2'd3);
    issue(C_SWAP, 2'd0, 16'h0, 16'h0);
    want_pc("R7 frame queued again", ent(2), 2'd2);
    stop_is("R7 requeued post", 16'h7201, 2'd2);
    stop_is("R4 frame 2 exit", ext(2), 2'd2);
    quiet_cmd("R9 queue drained", C_SWAP, 2'd0, 16'h0);
  endtask

  task automatic t_alloc_guard();
    issue(C_POST, 2'd0, 16'h8000, 16'h0);
    want_pc("R9 wake frame 0", ent(0), 2'd0);
    issue(C_ALLOC, 2'd0, 16'hAAAA, 16'hBBBB);
    want_quiet("R2 alloc on running frame");
    quiet_cmd("R6 queue frame 1", C_POST, 2'd1, 16'h8100);
    issue(C_ALLOC, 2'd1, 16'hCCCC, 16'hDDDD);
    want_quiet("R2 alloc on queued frame");
    stop_is("R2 running stack intact", 16'h8000, 2'd0);
    stop_is("R2 running exit unchanged", ext(0), 2'd0);
    issue(C_SWAP, 2'd0, 16'h0, 16'h0);
    want_pc("R2 queued entry unchanged", ent(1), 2'd1);
    stop_is("R2 queued stack intact", 16'h8100, 2'd1);
    stop_is("R2 queued exit unchanged", ext(1), 2'd1);
    issue(C_ALLOC, 2'd3, 16'h1E03, 16'h2E03);
    want_quiet("R2 alloc on idle frame");
    quiet_cmd("R6 queue frame 3", C_POST, 2'd3, 16'h8301);
    issue(C_SWAP, 2'd0, 16'h0, 16'h0);
    want_pc("R2 new entry used", 16'h1E03, 2'd3);
    stop_is("R3 frame 3 thread", 16'h8301, 2'd3);
    stop_is("R2 new exit used", 16'h2E03, 2'd3);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) issue(C_FORK, 2'd0, 16'h9000 + 16'(i), 16'h0);
    want_ovf("R10 full stack, no overflow yet", 1'b0);
    issue(C_FORK, 2'd0, 16'h9FFF, 16'h0);
    want_ovf("R10 overflow flagged", 1'b1);
    for (int i = 7; i >= 0; i--) stop_is("R10 dropped push absent", 16'h9000 + 16'(i), 2'd3);
    stop_is("R10 exit after overflow", 16'h2E03, 2'd3);
    want_ovf("R10 overflow sticky", 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_wake();
    t_lifo();
    t_post_active();
    t_enqueue();
    t_requeue();
    t_alloc_guard();
    t_overflow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule